// File: doc/BRIEF.md
# DRAM Controller Performance Counter Unit

This block watches a DRAM controller and counts what it does. It has four counter slices. Slice 0 counts clock cycles and acts as the master run gate. Slices 1 to 3 each count one event, chosen by an 8-bit select code. The controller reports events as single-cycle pulses on a seven-bit event bus, one line per event kind. Software uses a simple valid/address/data register port to program a control word per slice and to read back control words and count values.

The cycle slice controls the whole unit. While it is disabled or has wrapped, no slice advances. When it wraps it raises the only interrupt, a level signal, and that signal stays high until software writes its control word. An event slice that wraps sets its own overflow flag and keeps counting, with no interrupt.

Top module: `dpm_top`

## Requirements
- R1: After reset every control word, every count and `irq` are zero.
- R2: Register map: the control word of slice i is at byte offset 4*i and its count at 0x20+4*i, for i = 0..3. A read request returns data on `reg_rdata` with `reg_rvalid` high in the next cycle. Every other offset, including offsets not aligned to 4, reads as zero.
- R3: Control word layout: bit 0 is the overflow flag, bit 1 is the clear request, bit 2 is the enable, and bits 31:24 hold the select code. The clear bit always reads back as zero. All other bits read as zero.
- R4: While slice 0 is enabled and has not wrapped, it increments once per clock. The first increment happens on the edge after the edge that takes the enabling write.
- R5: An enabled event slice adds one for each clock in which its selected event line is high. Event bus bit k maps to a code as follows: bit 0 = 0x04 (read access), bit 1 = 0x05 (write access), bit 2 = 0x20 (read command), bit 3 = 0x21 (write command), bit 4 = 0x37 (refresh), bit 5 = 0x41 (ID-filtered read), bit 6 = 0x42 (ID-filtered write).
- R6: An event slice whose select code is not in the R5 list, including 0x00, never increments.
- R7: No slice advances while slice 0 is disabled or its overflow flag is set. Once slice 0 is enabled again, enabled slices resume from the value they held.
- R8: A write with the enable bit set to a slice that is already enabled has no effect. A write that sets enable and clear together on a disabled slice zeroes its count.
- R9: When slice 0 increments past the all-ones value it wraps to zero, sets its overflow flag, stops, and drives `irq` high.
- R10: When an event slice increments past the all-ones value it wraps to zero, sets its own overflow flag, keeps counting, and leaves `irq` low.
- R11: Any accepted control write clears that slice's overflow flag and sets its enable to the written bit. `irq` equals the overflow flag of slice 0 ANDed with its enable, so writing zero to control word 0 drops `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| reg_rdata | output | 32 | Read data |
| evt_i | input | 7 | Single-cycle event pulses, bit mapping in R5 |
| irq | output | 1 | Cycle-counter overflow interrupt (level) |

## Verification
Each access takes exactly one clock edge. Control writes take effect at that edge, and the first increment after an enable lands one edge later. A read returns the count as it stood before the read edge, and the data shows up on the following cycle. The driver changes inputs only at the falling edge and releases them just after the rising edge. Every task therefore covers one edge, so expected counts follow directly from the number of pulse and idle edges. The driver pushes each expected read word into a queue. The monitor pops one entry at each falling edge where `reg_rvalid` is high, and checks `irq` levels at falling edges once the cycle counter's wrap edge has passed.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    localparam int NUM_EVT = 7;
    localparam int OVF_BIT = 0;
    localparam int CLR_BIT = 1;
    localparam int EN_BIT  = 2;
    localparam int SEL_LSB = 24;

    typedef struct packed {
        logic [7:0] sel;
        logic       en;
        logic       ovf;
    } ctrl_t;

    typedef struct packed {
        logic       ok;
        logic [2:0] idx;
    } evt_map_t;

    // Select code to event bus line; ok = 0 for unsupported codes
    function automatic evt_map_t evt_lookup(input logic [7:0] code);
        evt_map_t m;
        m.ok  = 1'b1;
        m.idx = 3'd0;
        case (code)
            8'h04:   m.idx = 3'd0;
            8'h05:   m.idx = 3'd1;
            8'h20:   m.idx = 3'd2;
            8'h21:   m.idx = 3'd3;
            8'h37:   m.idx = 3'd4;
            8'h41:   m.idx = 3'd5;
            8'h42:   m.idx = 3'd6;
            default: m.ok  = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dpm_evt_match.sv
module dpm_evt_match
    import dpm_pkg::*;
(
    input  logic [7:0]         sel_i,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               hit_o
);

    evt_map_t map_w;

    always_comb begin
        map_w = evt_lookup(sel_i);
        hit_o = map_w.ok && evt_i[map_w.idx];
    end

endmodule

// File: rtl/dpm_slice.sv
module dpm_slice
    import dpm_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter bit IS_CYCLE = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               wr_en_i,
    input  logic               wr_clr_i,
    input  logic [7:0]         wr_sel_i,
    input  logic               run_glb_i,
    input  logic [NUM_EVT-1:0] evt_i,
    output ctrl_t              ctrl_o,
    output logic [CNT_W-1:0]   cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic hit_w;
    logic take_w;
    logic inc_w;

    dpm_evt_match u_match (
        .sel_i (st_q.ctrl.sel),
        .evt_i (evt_i),
        .hit_o (hit_w)
    );

    always_comb begin
        st_d   = st_q;
        // A re-enable of a running slice is dropped
        take_w = wr_i && !(wr_en_i && st_q.ctrl.en);
        inc_w  = st_q.ctrl.en &&
                 (IS_CYCLE ? !st_q.ctrl.ovf : (run_glb_i && hit_w));
        if (take_w) begin
            st_d.ctrl.en  = wr_en_i;
            st_d.ctrl.sel = wr_sel_i;
            st_d.ctrl.ovf = 1'b0;
            if (wr_en_i && wr_clr_i) begin
                st_d.cnt = '0;
            end
        end else if (inc_w) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_MAX) begin
                st_d.ctrl.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;
    assign cnt_o  = st_q.cnt;

    generate
        if (IS_CYCLE) begin : g_cyc_chk
            AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.ctrl.en && !st_q.ctrl.ovf && !wr_i)
                |=> st_q.cnt == $past(st_q.cnt) + 1'b1); // R4
        end else begin : g_evt_chk
            AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (!run_glb_i && !wr_i) |=> $stable(st_q.cnt)); // R7
            AST_EVT_WRAP_ON: assert property (@(posedge clk) disable iff (!rst_n)
                (!wr_i && run_glb_i && st_q.ctrl.en && hit_w && st_q.cnt == CNT_MAX)
                |=> (st_q.cnt == '0) && st_q.ctrl.ovf); // R10
            AST_UNSUP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                (!wr_i && !evt_lookup(st_q.ctrl.sel).ok) |=> $stable(st_q.cnt)); // R6
        end
    endgenerate

endmodule

// File: rtl/dpm_top.sv
module dpm_top
    import dpm_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_valid,
    input  logic               reg_write,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic               reg_rvalid,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               irq
);

    localparam int              IDX_W     = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
    localparam logic [ADDR_W-1:0] CNT_BASE = ADDR_W'(8'h20);
    localparam int              SPAN      = 4 * NUM_CNT;

    typedef struct packed {
        logic        rvalid;
        logic [31:0] rdata;
    } rd_t;

    rd_t              rd_d, rd_q;
    ctrl_t            ctrl_w [NUM_CNT];
    logic [CNT_W-1:0] cnt_w  [NUM_CNT];
    logic             run_glb_w;
    logic             in_ctrl_w, in_cnt_w;
    logic [IDX_W-1:0] ridx_w;
    logic [ADDR_W-1:0] coff_w;

    assign run_glb_w = ctrl_w[0].en && !ctrl_w[0].ovf;

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_slice
            logic wr_hit;
            assign wr_hit = reg_valid && reg_write && (reg_addr == ADDR_W'(4 * i));
            dpm_slice #(
                .CNT_W    (CNT_W),
                .IS_CYCLE (i == 0)
            ) u_slice (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_i      (wr_hit),
                .wr_en_i   (reg_wdata[EN_BIT]),
                .wr_clr_i  (reg_wdata[CLR_BIT]),
                .wr_sel_i  (reg_wdata[SEL_LSB +: 8]),
                .run_glb_i (run_glb_w),
                .evt_i     (evt_i),
                .ctrl_o    (ctrl_w[i]),
                .cnt_o     (cnt_w[i])
            );
        end
    endgenerate

    always_comb begin
        coff_w    = reg_addr - CNT_BASE;
        in_ctrl_w = (reg_addr[1:0] == 2'b00) && (int'(reg_addr) < SPAN);
        in_cnt_w  = (reg_addr[1:0] == 2'b00) && (reg_addr >= CNT_BASE) &&
                    (int'(coff_w) < SPAN);
        ridx_w    = in_ctrl_w ? reg_addr[IDX_W+1:2] : coff_w[IDX_W+1:2];
        rd_d      = '0;
        if (reg_valid && !reg_write) begin
            rd_d.rvalid = 1'b1;
            for (int i = 0; i < NUM_CNT; i++) begin
                if (ridx_w == IDX_W'(i)) begin
                    if (in_ctrl_w) begin
                        rd_d.rdata = {ctrl_w[i].sel, 21'b0, ctrl_w[i].en,
                                      1'b0, ctrl_w[i].ovf};
                    end else if (in_cnt_w) begin
                        rd_d.rdata = 32'(cnt_w[i]);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign reg_rvalid = rd_q.rvalid;
    assign reg_rdata  = rd_q.rdata;
    assign irq        = ctrl_w[0].ovf && ctrl_w[0].en;

    AST_IRQ_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cnt_w[0]) == {CNT_W{1'b1}}); // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write && !in_ctrl_w && !in_cnt_w)
        |=> reg_rvalid && (reg_rdata == 32'h0)); // R2
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_addr == '0 && !reg_wdata[EN_BIT])
        |=> !irq); // R11

endmodule

// File: tb/dpm_top_tb.sv
module dpm_top_tb;
    import dpm_pkg::*;

    localparam int CNT_W = 8;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_valid = 1'b0;
    logic               reg_write = 1'b0;
    logic [7:0]         reg_addr = '0;
    logic [31:0]        reg_wdata = '0;
    logic               reg_rvalid;
    logic [31:0]        reg_rdata;
    logic [NUM_EVT-1:0] evt_i = '0;
    logic               irq;

    int    n_chk  = 0;
    int    n_fail = 0;
    item_t sb_q[$];

    always #2 clk = ~clk;

    dpm_top #(.NUM_CNT(4), .CNT_W(CNT_W), .ADDR_W(8)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_valid  (reg_valid),
        .reg_write  (reg_write),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rvalid (reg_rvalid),
        .reg_rdata  (reg_rdata),
        .evt_i      (evt_i),
        .irq        (irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        @(negedge clk);
        sb_q.push_back(it);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(posedge clk); #1;
        reg_valid = 1'b0;
    endtask

    task automatic pulse(input logic [NUM_EVT-1:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            evt_i = m;
            @(posedge clk); #1;
            evt_i = '0;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
    endtask

    // Monitor: pops one expected word per returned read
    always @(negedge clk) begin
        if (reg_rvalid) begin
            if (sb_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R2: unexpected read data %h expected none", reg_rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(reg_rdata, it.exp, it.tag);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R2 unmapped offsets
        @(negedge clk);
        check({31'b0, irq}, 32'h0, "R1 irq after reset");
        for (int i = 0; i < 4; i++) begin
            rd(8'(4 * i), 32'h0, "R1 ctrl reset");
            rd(8'(8'h20 + 4 * i), 32'h0, "R1 count reset");
        end
        rd(8'h10, 32'h0, "R2 unmapped 0x10");
        rd(8'h40, 32'h0, "R2 unmapped 0x40");
        rd(8'h02, 32'h0, "R2 misaligned");

        // R7 gate: event slices enabled but cycle slice off
        wr(8'h04, 32'h0400_0004);
        wr(8'h08, 32'h0500_0004);
        wr(8'h0C, 32'h0000_0004);
        pulse(7'h7F, 5);
        rd(8'h24, 32'h0, "R7 no count while cycle slice off");

        // R5 counting, R6 unsupported code, R3 readback
        wr(8'h00, 32'h0000_0006);
        pulse(7'h01, 7);
        pulse(7'h02, 3);
        pulse(7'h7F, 2);
        rd(8'h24, 32'd9, "R5 read access count");
        rd(8'h28, 32'd5, "R5 write access count");
        rd(8'h2C, 32'd0, "R6 code 0x00 on event slice");
        rd(8'h04, 32'h0400_0004, "R3 ctrl readback clear reads 0");
        rd(8'h0C, 32'h0000_0004, "R3 ctrl readback slice 3");

        // R8 re-enable ignored, then zero + enable/clear
        wr(8'h04, 32'h2000_0006);
        rd(8'h24, 32'd9, "R8 re-enable ignored count");
        rd(8'h04, 32'h0400_0004, "R8 re-enable ignored select");
        wr(8'h04, 32'h0);
        rd(8'h04, 32'h0, "R11 zero write clears enable");
        wr(8'h04, 32'h2000_0006);
        pulse(7'h04, 4);
        rd(8'h24, 32'd4, "R8 clear then read command count");
        wr(8'h0C, 32'h0);
        wr(8'h0C, 32'h3700_0006);
        pulse(7'h30, 3);
        rd(8'h2C, 32'd3, "R5 refresh count");

        // R7 disable cycle slice freezes, re-enable resumes; R4 stepping
        wr(8'h00, 32'h0);
        pulse(7'h7F, 3);
        rd(8'h24, 32'd4, "R7 frozen while disabled");
        rd(8'h2C, 32'd3, "R7 frozen slice 3");
        wr(8'h00, 32'h0000_0006);
        rd(8'h20, 32'd0, "R4 cycle count at first read");
        rd(8'h20, 32'd1, "R4 cycle count one later");
        idle(5);
        rd(8'h20, 32'd7, "R4 cycle count after idle");
        pulse(7'h04, 2);
        rd(8'h24, 32'd6, "R7 resume after re-enable");

        // R10 event slice wraps silently
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h0000_0006);
        wr(8'h08, 32'h0);
        wr(8'h08, 32'h0500_0006);
        pulse(7'h02, 250);
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h0000_0006);
        pulse(7'h02, 10);
        rd(8'h28, 32'd4, "R10 wrapped count continues");
        rd(8'h08, 32'h0500_0005, "R10 overflow flag set");
        @(negedge clk);
        check({31'b0, irq}, 32'h0, "R10 no irq on event wrap");

        // R9 cycle slice wrap freezes everything and raises irq
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h0000_0006);
        idle(270);
        @(negedge clk);
        check({31'b0, irq}, 32'h1, "R9 irq after cycle wrap");
        rd(8'h00, 32'h0000_0005, "R9 overflow flag slice 0");
        rd(8'h20, 32'd0, "R9 cycle count wrapped and held");
        pulse(7'h04, 5);
        rd(8'h24, 32'd6, "R9 event slice frozen");

        // R11 zero write drops irq, re-enable resumes
        wr(8'h00, 32'h0);
        @(negedge clk);
        check({31'b0, irq}, 32'h0, "R11 irq cleared");
        rd(8'h00, 32'h0, "R11 ctrl0 cleared");
        wr(8'h00, 32'h0000_0006);
        pulse(7'h04, 2);
        rd(8'h24, 32'd8, "R7 resume after overflow clear");

        idle(3);
        if (sb_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R2: actual %0d reads unanswered expected 0", sb_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule